// File: doc/BRIEF.md
# Tile Control Sequencer

This block drives the datapath units of one processing tile. It keeps a small control memory holding, for every unit, one complete configuration word per context (eight contexts by default). A 3-bit context register selects which set of words is presented. On every clock edge the block can move to another context, so the configuration of every unit in the tile may change from one cycle to the next.

The next context comes from a programmable sum-of-products over a vector of status flags returned by the datapath. Each context owns a few product terms and two target contexts. If any enabled term matches the flags, the block goes to the first target. Otherwise it goes to the second. A single write port loads configuration words, product terms and target pairs. A hold input freezes the sequencer. The instruction outputs are registered. A word written into the memory reaches the outputs only when a later step reloads the output register, so the word in use during a cycle never changes partway through.

Top module: `tile_ctrl_seq`

## Requirements
- R1: After reset the context output is 0, every unit's instruction output is all zeros, every product term is disabled and every target is context 0, so the sequencer stays in context 0 whatever the flags are.
- R2: A write with kind 0 stores `wr_data_i` as the word for context `wr_ctx_i` and unit `wr_idx_i`. A unit index of `N_UNITS` or more changes no stored word.
- R3: Unit u's word appears on `instr_o[u*INSTR_W +: INSTR_W]`. After a clock edge with hold low, that slice holds the word stored for unit u in the context just entered, as the memory stood before that edge.
- R4: A write with kind 1 programs term `wr_idx_i` of context `wr_ctx_i`: care mask in data bits [FLAG_W-1:0], value in bits [2*FLAG_W-1:FLAG_W], enable in bit 2*FLAG_W. A term is true when it is enabled and the flags equal the value on every bit set in the care mask. An enabled term with a zero care mask is always true. A disabled term is never true.
- R5: A write with kind 2 sets the targets of context `wr_ctx_i`: target A in data bits [CTX_W-1:0], target B in bits [2*CTX_W-1:CTX_W]. On a clock edge with hold low, the context becomes target A if any term of the current context is true, and target B otherwise.
- R6: While hold is high, clock edges change neither the context output nor any instruction output.
- R7: A word written into the memory is not visible on the outputs until the first step edge that comes strictly after the write edge. This applies to a write made during hold and to a write made on the same edge as a step into that context.
- R8: A write with kind 3 changes no word, term or target.
- R9: The context may take a different value on each of several consecutive clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hold_i | input | 1 | Freeze context and instruction outputs |
| flags_i | input | FLAG_W | Status flags from the datapath units |
| wr_en_i | input | 1 | Write strobe |
| wr_kind_i | input | 2 | 0 word, 1 product term, 2 targets, 3 none |
| wr_ctx_i | input | CTX_W | Context addressed by the write |
| wr_idx_i | input | IDX_W | Unit index (kind 0) or term index (kind 1) |
| wr_data_i | input | INSTR_W | Write payload |
| ctx_o | output | CTX_W | Current context |
| instr_o | output | N_UNITS*INSTR_W | Per-unit configuration words of the current context |

## Verification
Every result is due exactly one rising edge after the inputs that cause it. The context register and the instruction registers load on the same edge, from the flags and memory as they stood just before that edge. A write becomes part of the memory at its own edge, but it is seen on the outputs only at the next step edge after that. The bench applies all inputs at a falling edge and samples at the following falling edge. Each sample therefore sees the effect of exactly one rising edge. The deferred-write cases check the old word in the first sample and the new word one step later.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  typedef enum logic [1:0] {
    WK_INSTR  = 2'd0,
    WK_TERM   = 2'd1,
    WK_TARGET = 2'd2,
    WK_NONE   = 2'd3
  } wr_kind_e;
endpackage

// File: rtl/tcs_instr_store.sv
module tcs_instr_store #(
  parameter int N_UNITS = 7,
  parameter int N_CTX   = 8,
  parameter int INSTR_W = 24,
  parameter int CTX_W   = 3,
  parameter int IDX_W   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [CTX_W-1:0]           wr_ctx,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [INSTR_W-1:0]         wr_data,
  input  logic                       hold,
  input  logic [CTX_W-1:0]           load_ctx,
  output logic [N_UNITS*INSTR_W-1:0] instr_o
);
  localparam logic [IDX_W-1:0] LAST_UNIT = IDX_W'(N_UNITS - 1);

  logic [INSTR_W-1:0] mem    [N_CTX][N_UNITS];
  logic [INSTR_W-1:0] word_q [N_UNITS];

  // Control memory: one word per context and unit.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < N_CTX; c++)
        for (int u = 0; u < N_UNITS; u++)
          mem[c][u] <= '0;
    end else if (wr_en && (wr_idx <= LAST_UNIT)) begin
      mem[wr_ctx][wr_idx] <= wr_data;
    end
  end

  // Output registers reload only on a step, reading the pre-edge memory.
  for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
    always_ff @(posedge clk) begin
      if (!rst_n)     word_q[u] <= '0;
      else if (!hold) word_q[u] <= mem[load_ctx][u];
    end
    assign instr_o[u*INSTR_W +: INSTR_W] = word_q[u];
  end

  p_hold_instr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(instr_o))
    else $error("instruction outputs moved under hold");
endmodule

// File: rtl/tcs_sop_next.sv
module tcs_sop_next #(
  parameter int N_CTX   = 8,
  parameter int N_TERMS = 4,
  parameter int FLAG_W  = 8,
  parameter int CTX_W   = 3,
  parameter int IDX_W   = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                term_wr,
  input  logic                tgt_wr,
  input  logic [CTX_W-1:0]    wr_ctx,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [2*FLAG_W:0]   term_data,
  input  logic [2*CTX_W-1:0]  tgt_data,
  input  logic [CTX_W-1:0]    cur_ctx,
  input  logic [FLAG_W-1:0]   flags,
  output logic [CTX_W-1:0]    next_ctx
);
  localparam int TERM_W = (N_TERMS > 1) ? $clog2(N_TERMS) : 1;
  localparam logic [IDX_W-1:0] LAST_TERM = IDX_W'(N_TERMS - 1);

  logic [FLAG_W-1:0]  care_q [N_CTX][N_TERMS];
  logic [FLAG_W-1:0]  val_q  [N_CTX][N_TERMS];
  logic [N_TERMS-1:0] en_q   [N_CTX];
  logic [CTX_W-1:0]   tgt_a_q [N_CTX];
  logic [CTX_W-1:0]   tgt_b_q [N_CTX];
  logic [N_TERMS-1:0] term_hit;
  logic               any_hit;
  logic [TERM_W-1:0]  term_sel;

  assign term_sel = wr_idx[TERM_W-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < N_CTX; c++) begin
        en_q[c]    <= '0;
        tgt_a_q[c] <= '0;
        tgt_b_q[c] <= '0;
        for (int t = 0; t < N_TERMS; t++) begin
          care_q[c][t] <= '0;
          val_q[c][t]  <= '0;
        end
      end
    end else begin
      if (term_wr && (wr_idx <= LAST_TERM)) begin
        care_q[wr_ctx][term_sel]  <= term_data[FLAG_W-1:0];
        val_q[wr_ctx][term_sel]   <= term_data[2*FLAG_W-1:FLAG_W];
        en_q[wr_ctx][term_sel]    <= term_data[2*FLAG_W];
      end
      if (tgt_wr) begin
        tgt_a_q[wr_ctx] <= tgt_data[CTX_W-1:0];
        tgt_b_q[wr_ctx] <= tgt_data[2*CTX_W-1:CTX_W];
      end
    end
  end

  // One AND term per product: flags compared with value on cared bits.
  for (genvar t = 0; t < N_TERMS; t++) begin : g_term
    assign term_hit[t] = en_q[cur_ctx][t] &
      (((flags ^ val_q[cur_ctx][t]) & care_q[cur_ctx][t]) == '0);
  end

  assign any_hit  = |term_hit;
  assign next_ctx = any_hit ? tgt_a_q[cur_ctx] : tgt_b_q[cur_ctx];

  p_care_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q[cur_ctx][0] && (care_q[cur_ctx][0] == '0)) |-> any_hit)
    else $error("enabled term with empty care mask did not fire");
endmodule

// File: rtl/tile_ctrl_seq.sv
module tile_ctrl_seq
  import tcs_pkg::*;
#(
  parameter int N_UNITS = 7,
  parameter int N_CTX   = 8,
  parameter int N_TERMS = 4,
  parameter int FLAG_W  = 8,
  parameter int INSTR_W = 24,
  localparam int CTX_W  = $clog2(N_CTX),
  localparam int IDX_W  = $clog2((N_UNITS > N_TERMS) ? N_UNITS : N_TERMS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       hold_i,
  input  logic [FLAG_W-1:0]          flags_i,
  input  logic                       wr_en_i,
  input  logic [1:0]                 wr_kind_i,
  input  logic [CTX_W-1:0]           wr_ctx_i,
  input  logic [IDX_W-1:0]           wr_idx_i,
  input  logic [INSTR_W-1:0]         wr_data_i,
  output logic [CTX_W-1:0]           ctx_o,
  output logic [N_UNITS*INSTR_W-1:0] instr_o
);
  wr_kind_e         kind;
  logic             instr_wr, term_wr, tgt_wr;
  logic [CTX_W-1:0] ctx_q, next_ctx;

  assign kind     = wr_kind_e'(wr_kind_i);
  assign instr_wr = wr_en_i && (kind == WK_INSTR);
  assign term_wr  = wr_en_i && (kind == WK_TERM);
  assign tgt_wr   = wr_en_i && (kind == WK_TARGET);

  tcs_sop_next #(
    .N_CTX(N_CTX), .N_TERMS(N_TERMS), .FLAG_W(FLAG_W),
    .CTX_W(CTX_W), .IDX_W(IDX_W)
  ) u_sop (
    .clk      (clk),
    .rst_n    (rst_n),
    .term_wr  (term_wr),
    .tgt_wr   (tgt_wr),
    .wr_ctx   (wr_ctx_i),
    .wr_idx   (wr_idx_i),
    .term_data(wr_data_i[2*FLAG_W:0]),
    .tgt_data (wr_data_i[2*CTX_W-1:0]),
    .cur_ctx  (ctx_q),
    .flags    (flags_i),
    .next_ctx (next_ctx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       ctx_q <= '0;
    else if (!hold_i) ctx_q <= next_ctx;
  end

  tcs_instr_store #(
    .N_UNITS(N_UNITS), .N_CTX(N_CTX), .INSTR_W(INSTR_W),
    .CTX_W(CTX_W), .IDX_W(IDX_W)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (instr_wr),
    .wr_ctx  (wr_ctx_i),
    .wr_idx  (wr_idx_i),
    .wr_data (wr_data_i),
    .hold    (hold_i),
    .load_ctx(next_ctx),
    .instr_o (instr_o)
  );

  assign ctx_o = ctx_q;

  p_hold_ctx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold_i |=> $stable(ctx_q))
    else $error("context moved under hold");

  p_step_ctx_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_i |=> (ctx_q == $past(next_ctx)))
    else $error("context did not follow next-state logic");
endmodule

// File: tb/test_tile_ctrl_seq.sv
module test_tile_ctrl_seq;
  localparam int NU = 7;
  localparam int W  = 24;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            hold_i;
  logic [7:0]      flags_i;
  logic            wr_en_i;
  logic [1:0]      wr_kind_i;
  logic [2:0]      wr_ctx_i;
  logic [2:0]      wr_idx_i;
  logic [W-1:0]    wr_data_i;
  logic [2:0]      ctx_o;
  logic [NU*W-1:0] instr_o;

  int tests = 0;
  int fails = 0;

  tile_ctrl_seq i_tile_ctrl_seq (
    .clk(clk), .rst_n(rst_n), .hold_i(hold_i), .flags_i(flags_i),
    .wr_en_i(wr_en_i), .wr_kind_i(wr_kind_i), .wr_ctx_i(wr_ctx_i),
    .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
    .ctx_o(ctx_o), .instr_o(instr_o)
  );

  always #5 clk = ~clk;

  // {hold, flags[7:0], expected context}
  localparam logic [11:0] VEC [14] = '{
    {1'b0, 8'h00, 3'd0}, {1'b0, 8'h01, 3'd1}, {1'b1, 8'h01, 3'd1},
    {1'b0, 8'h00, 3'd2}, {1'b0, 8'h35, 3'd3}, {1'b0, 8'hFF, 3'd4},
    {1'b0, 8'h80, 3'd2}, {1'b0, 8'hA3, 3'd3}, {1'b0, 8'h00, 3'd4},
    {1'b0, 8'h00, 3'd0}, {1'b0, 8'h01, 3'd1}, {1'b0, 8'h00, 3'd2},
    {1'b0, 8'h00, 3'd5}, {1'b0, 8'h00, 3'd0}
  };

  localparam logic [W-1:0] NEW_A = 24'hBEEF01;
  localparam logic [W-1:0] NEW_B = 24'h5A5A02;

  function automatic logic [W-1:0] word(input int c, input int u);
    return {4'hC, 1'b0, 3'(c), 1'b0, 3'(u), 12'h3A5};
  endfunction

  function automatic logic [W-1:0] term(input bit en, input logic [7:0] val,
                                        input logic [7:0] care);
    return {7'd0, en, val, care};
  endfunction

  // Drive at a falling edge, then wait for the next falling edge.
  task automatic cyc(input bit hold, input logic [7:0] fl, input bit we,
                     input logic [1:0] kind, input int c, input int idx,
                     input logic [W-1:0] data);
    hold_i    = hold;
    flags_i   = fl;
    wr_en_i   = we;
    wr_kind_i = kind;
    wr_ctx_i  = 3'(c);
    wr_idx_i  = 3'(idx);
    wr_data_i = data;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic chk(input string req, input logic [2:0] ectx,
                     input logic [NU*W-1:0] ewords);
    tests++;
    if (ctx_o !== ectx || instr_o !== ewords) begin
      fails++;
      $display("FAIL %s: ctx=%0d words=%h expected ctx=%0d words=%h",
               req, ctx_o, instr_o, ectx, ewords);
    end
  endtask

  function automatic logic [NU*W-1:0] all_words(input int c);
    logic [NU*W-1:0] v;
    for (int u = 0; u < NU; u++) v[u*W +: W] = word(c, u);
    return v;
  endfunction

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog: run did not end, actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [NU*W-1:0] exp0;
    rst_n = 1'b0; hold_i = 1'b1; flags_i = '0; wr_en_i = 1'b0;
    wr_kind_i = '0; wr_ctx_i = '0; wr_idx_i = '0; wr_data_i = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    chk("R1 reset", 3'd0, '0);

    // Program words and next-state logic under hold.
    for (int c = 0; c < 8; c++)
      for (int u = 0; u < NU; u++)
        cyc(1, 8'h00, 1, 2'd0, c, u, word(c, u));
    cyc(1, 0, 1, 2'd1, 0, 0, term(1, 8'h01, 8'h01));
    cyc(1, 0, 1, 2'd2, 0, 0, {18'd0, 3'd0, 3'd1});
    cyc(1, 0, 1, 2'd1, 1, 0, term(1, 8'h00, 8'h00));
    cyc(1, 0, 1, 2'd2, 1, 0, {18'd0, 3'd7, 3'd2});
    cyc(1, 0, 1, 2'd1, 2, 0, term(1, 8'h05, 8'h0F));
    cyc(1, 0, 1, 2'd1, 2, 1, term(1, 8'hA0, 8'hF0));
    cyc(1, 0, 1, 2'd2, 2, 0, {18'd0, 3'd5, 3'd3});
    cyc(1, 0, 1, 2'd1, 3, 0, term(0, 8'h00, 8'h00)); // disabled, R4
    cyc(1, 0, 1, 2'd2, 3, 0, {18'd0, 3'd4, 3'd6});
    cyc(1, 0, 1, 2'd1, 4, 3, term(1, 8'h00, 8'h80));
    cyc(1, 0, 1, 2'd2, 4, 0, {18'd0, 3'd2, 3'd0});
    chk("R6 hold during programming", 3'd0, '0);

    // Table walk: R3, R4, R5, R6, R9.
    for (int i = 0; i < 14; i++) begin
      cyc(VEC[i][11], VEC[i][10:3], 0, 2'd0, 0, 0, '0);
      chk("R3/R4/R5/R6/R9 table", VEC[i][2:0], all_words(int'(VEC[i][2:0])));
    end

    // R7: write under hold to current context stays invisible.
    exp0 = all_words(0);
    cyc(1, 8'h00, 1, 2'd0, 0, 0, NEW_A);
    chk("R7 held write hidden", 3'd0, exp0);
    cyc(0, 8'h00, 0, 2'd0, 0, 0, '0);
    exp0[0 +: W] = NEW_A;
    chk("R7 held write shown after step", 3'd0, exp0);
    // R7: write on the same edge as the step into that context.
    cyc(0, 8'h00, 1, 2'd0, 0, 1, NEW_B);
    chk("R7 same-edge write hidden", 3'd0, exp0);
    cyc(0, 8'h00, 0, 2'd0, 0, 0, '0);
    exp0[W +: W] = NEW_B;
    chk("R7 same-edge write shown", 3'd0, exp0);

    // R2: unit index out of range is dropped.
    cyc(1, 8'h00, 1, 2'd0, 0, 7, 24'hDEAD00);
    cyc(0, 8'h00, 0, 2'd0, 0, 0, '0);
    chk("R2 out-of-range unit", 3'd0, exp0);

    // R8: kind 3 writes nothing.
    cyc(1, 8'h00, 1, 2'd3, 0, 0, 24'hFFFFFF);
    cyc(1, 8'h00, 1, 2'd3, 1, 0, 24'hFFFFFF);
    cyc(0, 8'h01, 0, 2'd0, 0, 0, '0);
    chk("R8 kind3 ctx0 targets", 3'd1, all_words(1));
    cyc(0, 8'h00, 0, 2'd0, 0, 0, '0);
    cyc(0, 8'h00, 0, 2'd0, 0, 0, '0);
    chk("R8 kind3 ctx2 path", 3'd5, all_words(5));
    cyc(0, 8'h00, 0, 2'd0, 0, 0, '0);
    chk("R8 kind3 ctx0 words", 3'd0, exp0);

    // R1: second reset clears terms; flags that matched before do nothing.
    rst_n = 1'b0;
    cyc(0, 8'h01, 0, 2'd0, 0, 0, '0);
    rst_n = 1'b1;
    chk("R1 reset again", 3'd0, '0);
    cyc(0, 8'h01, 0, 2'd0, 0, 0, '0);
    chk("R1 terms cleared", 3'd0, '0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule